// File: doc/BRIEF.md
# PCIe Host Bring-Up Sequencer

This block steps a PCIe root-complex controller and its card slot from a cold, fully reset condition to an enabled link. It drives every control line in a fixed order. First it powers the slot while both resets are held. It keeps the resets held for a long, programmable interval, releases them, and then brackets PHY register programming with a PHY hold-reset and an auxiliary clock gate. Last, it selects root-complex mode and enables link training. The link training, the PHY programming engine and the controller core lie outside the block. They are seen only through a start pulse to the engine and its done pulse.

A one-cycle start pulse begins the sequence from idle. A shutdown request at any point after start takes the link down. It pulls the slot reset low, then the controller reset, and then returns every output to its reset value, so that a later boot finds a clean state. All outputs are registered and change only on a state transition.

Top module: `pcie_host_bringup`

## Requirements
- R1: While reset is high, and afterwards until a start is taken, the outputs are: both resets low, power off, auxiliary clock gated, PHY hold-reset low, power-up reset low, device type 0, link training off, busy low, engine start low.
- R2: A start pulse in idle raises slot power and busy on the next clock edge, with both resets still low.
- R3: Power stays on with both resets low for exactly HOLD_CYCLES cycles. The controller reset is then released, and the slot reset is released one cycle after that.
- R4: The auxiliary clock is enabled one cycle after slot reset release, and the PHY hold-reset is raised one cycle after the clock.
- R5: The power-up reset is released one cycle after the hold-reset rises, together with a one-cycle engine start pulse. The sequencer then waits for the engine done pulse. If done arrives in cycle k after the wait began (k >= 1), the next step appears k cycles after the wait state. A done pulse at any other time is ignored.
- R6: After done, one cycle per step: the auxiliary clock is gated, then the PHY hold-reset is cleared, then the clock is re-enabled.
- R7: One cycle after the re-enable, the device type becomes 4 (root complex). One cycle later link training is enabled and busy falls. This state holds until shutdown.
- R8: A start pulse is ignored in every state other than idle.
- R9: A shutdown request in any state other than idle first drives the slot reset low and link training off, with busy low. The next cycle drives the controller reset low, and the cycle after that restores the R1 values. In idle a shutdown request changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin bring-up (pulse, taken in idle only) |
| prog_done_i | input | 1 | PHY programming finished (pulse) |
| shutdown_i | input | 1 | Take the link down (pulse) |
| slot_rst_n_o | output | 1 | Slot reset, active low |
| core_rst_n_o | output | 1 | Controller reset, active low |
| slot_pwr_en_o | output | 1 | Slot power enable |
| aux_clk_en_o | output | 1 | Auxiliary clock enable |
| phy_hold_rst_o | output | 1 | Holds the link state machine / PHY in reset for programming |
| pwrup_rst_n_o | output | 1 | Power-up reset, active low |
| dev_type_o | output | 4 | Device-type value (4 = root complex) |
| link_train_en_o | output | 1 | Link training enable |
| busy_o | output | 1 | High from start until link training is enabled |
| phy_prog_go_o | output | 1 | One-cycle start pulse to the PHY programming engine |

## Verification
The bench builds the block with HOLD_CYCLES set to 20 instead of the default of 12.5 million cycles. The exact length of the power-on reset hold can then be measured edge for edge, and the whole sequence can be repeated several times in one short run. These repeats let the bench interrupt the sequence during the hold wait and during the programming wait. They also let it restart after a shutdown and inject stray start and done pulses, with each resulting output change compared against an expected ordered list.

// File: rtl/pbs_pkg.sv
package pbs_pkg;

    localparam int DEV_TYPE_W = 4;
    localparam logic [DEV_TYPE_W-1:0] DEV_TYPE_ROOT = 4'd4;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PWR_WAIT,
        ST_REL_CORE,
        ST_REL_SLOT,
        ST_AUX_ON,
        ST_HOLD_ON,
        ST_PWRUP,
        ST_PROG_WAIT,
        ST_AUX_OFF,
        ST_HOLD_CLR,
        ST_AUX_RE,
        ST_SET_TYPE,
        ST_LINK_UP,
        ST_SD_SLOT,
        ST_SD_CORE
    } seq_state_e;

    typedef struct packed {
        logic                  slot_rst_n;
        logic                  core_rst_n;
        logic                  slot_pwr_en;
        logic                  aux_clk_en;
        logic                  phy_hold_rst;
        logic                  pwrup_rst_n;
        logic [DEV_TYPE_W-1:0] dev_type;
        logic                  link_train_en;
        logic                  busy;
        logic                  prog_go;
    } ctl_t;

    localparam ctl_t CTL_RESET = '0;

    function automatic logic is_bringup(seq_state_e s);
        return (s >= ST_PWR_WAIT) && (s <= ST_LINK_UP);
    endfunction

    // Control word for the state being entered; shutdown states edit the
    // word currently driven so that lines already low are left alone.
    function automatic ctl_t ctl_next(seq_state_e s, ctl_t prev);
        ctl_t c;
        c = CTL_RESET;
        if (is_bringup(s)) begin
            c.slot_pwr_en   = 1'b1;
            c.core_rst_n    = (s >= ST_REL_CORE);
            c.slot_rst_n    = (s >= ST_REL_SLOT);
            c.aux_clk_en    = ((s >= ST_AUX_ON) && (s < ST_AUX_OFF)) || (s >= ST_AUX_RE);
            c.phy_hold_rst  = (s >= ST_HOLD_ON) && (s < ST_HOLD_CLR);
            c.pwrup_rst_n   = (s >= ST_PWRUP);
            c.prog_go       = (s == ST_PWRUP);
            c.dev_type      = (s >= ST_SET_TYPE) ? DEV_TYPE_ROOT : '0;
            c.link_train_en = (s == ST_LINK_UP);
            c.busy          = (s != ST_LINK_UP);
        end else if (s == ST_SD_SLOT) begin
            c               = prev;
            c.slot_rst_n    = 1'b0;
            c.link_train_en = 1'b0;
            c.busy          = 1'b0;
            c.prog_go       = 1'b0;
        end else if (s == ST_SD_CORE) begin
            c               = prev;
            c.core_rst_n    = 1'b0;
        end
        return c;
    endfunction

endpackage

// File: rtl/pbs_wait_timer.sv
module pbs_wait_timer #(
    parameter int CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    output logic expired_o
);
    localparam int CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/pbs_fsm.sv
module pbs_fsm
    import pbs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic       prog_done_i,
    input  logic       shutdown_i,
    input  logic       wait_expired_i,
    output seq_state_e state_q_o,
    output seq_state_e state_d_o
);
    seq_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (start_i) state_d = ST_PWR_WAIT;
            ST_PWR_WAIT:  if (wait_expired_i) state_d = ST_REL_CORE;
            ST_REL_CORE:  state_d = ST_REL_SLOT;
            ST_REL_SLOT:  state_d = ST_AUX_ON;
            ST_AUX_ON:    state_d = ST_HOLD_ON;
            ST_HOLD_ON:   state_d = ST_PWRUP;
            ST_PWRUP:     state_d = ST_PROG_WAIT;
            ST_PROG_WAIT: if (prog_done_i) state_d = ST_AUX_OFF;
            ST_AUX_OFF:   state_d = ST_HOLD_CLR;
            ST_HOLD_CLR:  state_d = ST_AUX_RE;
            ST_AUX_RE:    state_d = ST_SET_TYPE;
            ST_SET_TYPE:  state_d = ST_LINK_UP;
            ST_LINK_UP:   state_d = ST_LINK_UP;
            ST_SD_SLOT:   state_d = ST_SD_CORE;
            ST_SD_CORE:   state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
        if (shutdown_i && is_bringup(state_q)) begin
            state_d = ST_SD_SLOT;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    assign state_q_o = state_q;
    assign state_d_o = state_d;
endmodule

// File: rtl/pbs_ctl_regs.sv
module pbs_ctl_regs
    import pbs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  seq_state_e state_d_i,
    output ctl_t       ctl_o
);
    ctl_t ctl_q;

    always_ff @(posedge clk) begin
        if (rst) ctl_q <= CTL_RESET;
        else     ctl_q <= ctl_next(state_d_i, ctl_q);
    end

    assign ctl_o = ctl_q;
endmodule

// File: rtl/pcie_host_bringup.sv
module pcie_host_bringup
    import pbs_pkg::*;
#(
    parameter int CLK_HZ      = 125_000_000,
    parameter int HOLD_US     = 100_000,
    parameter int HOLD_CYCLES = (CLK_HZ / 1_000_000) * HOLD_US
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start_i,
    input  logic                  prog_done_i,
    input  logic                  shutdown_i,
    output logic                  slot_rst_n_o,
    output logic                  core_rst_n_o,
    output logic                  slot_pwr_en_o,
    output logic                  aux_clk_en_o,
    output logic                  phy_hold_rst_o,
    output logic                  pwrup_rst_n_o,
    output logic [DEV_TYPE_W-1:0] dev_type_o,
    output logic                  link_train_en_o,
    output logic                  busy_o,
    output logic                  phy_prog_go_o
);
    seq_state_e state_q, state_d;
    logic       wait_expired;
    ctl_t       ctl;

    pbs_wait_timer #(.CYCLES(HOLD_CYCLES)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .run_i     (state_q == ST_PWR_WAIT),
        .expired_o (wait_expired)
    );

    pbs_fsm u_fsm (
        .clk            (clk),
        .rst            (rst),
        .start_i        (start_i),
        .prog_done_i    (prog_done_i),
        .shutdown_i     (shutdown_i),
        .wait_expired_i (wait_expired),
        .state_q_o      (state_q),
        .state_d_o      (state_d)
    );

    pbs_ctl_regs u_ctl (
        .clk       (clk),
        .rst       (rst),
        .state_d_i (state_d),
        .ctl_o     (ctl)
    );

    assign slot_rst_n_o    = ctl.slot_rst_n;
    assign core_rst_n_o    = ctl.core_rst_n;
    assign slot_pwr_en_o   = ctl.slot_pwr_en;
    assign aux_clk_en_o    = ctl.aux_clk_en;
    assign phy_hold_rst_o  = ctl.phy_hold_rst;
    assign pwrup_rst_n_o   = ctl.pwrup_rst_n;
    assign dev_type_o      = ctl.dev_type;
    assign link_train_en_o = ctl.link_train_en;
    assign busy_o          = ctl.busy;
    assign phy_prog_go_o   = ctl.prog_go;
endmodule

// File: rtl/pbs_checker.sv
module pbs_checker #(
    parameter int HOLD_CYCLES = 16
) (
    input logic       clk,
    input logic       rst,
    input logic       slot_rst_n,
    input logic       core_rst_n,
    input logic       slot_pwr_en,
    input logic       aux_clk_en,
    input logic       phy_hold_rst,
    input logic       pwrup_rst_n,
    input logic [3:0] dev_type,
    input logic       link_train_en,
    input logic       busy,
    input logic       prog_go
);
    logic [31:0] dwell_q;

    always_ff @(posedge clk) begin
        if (rst || !(slot_pwr_en && !core_rst_n)) dwell_q <= '0;
        else if (dwell_q != 32'hFFFF_FFFF)       dwell_q <= dwell_q + 1'b1;
    end

    // R1
    reset_values_chk: assert property (@(posedge clk)
        rst |=> (!slot_rst_n && !core_rst_n && !slot_pwr_en && !aux_clk_en &&
                 !phy_hold_rst && !pwrup_rst_n && dev_type == 4'd0 &&
                 !link_train_en && !busy && !prog_go));

    // R2
    power_under_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(slot_pwr_en) |-> (!slot_rst_n && !core_rst_n));

    // R3
    hold_dwell_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(core_rst_n) |-> (dwell_q >= 32'(HOLD_CYCLES)));

    // R3
    release_order_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(slot_rst_n) |-> $past(core_rst_n));

    // R4
    hold_after_clock_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(phy_hold_rst) |-> (aux_clk_en && $past(aux_clk_en)));

    // R5
    pwrup_under_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pwrup_rst_n) |-> phy_hold_rst);

    // R5
    go_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        prog_go |=> !prog_go);

    // R7
    link_after_type_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(link_train_en) |-> ($past(dev_type) == 4'd4 && !busy));

    // R9
    entry_order_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(core_rst_n) |-> (!slot_rst_n && $past(!slot_rst_n)));
endmodule

bind pcie_host_bringup pbs_checker #(.HOLD_CYCLES(HOLD_CYCLES)) u_pbs_chk (
    .clk           (clk),
    .rst           (rst),
    .slot_rst_n    (slot_rst_n_o),
    .core_rst_n    (core_rst_n_o),
    .slot_pwr_en   (slot_pwr_en_o),
    .aux_clk_en    (aux_clk_en_o),
    .phy_hold_rst  (phy_hold_rst_o),
    .pwrup_rst_n   (pwrup_rst_n_o),
    .dev_type      (dev_type_o),
    .link_train_en (link_train_en_o),
    .busy          (busy_o),
    .prog_go       (phy_prog_go_o)
);

// File: tb/pcie_host_bringup_test.sv
module pcie_host_bringup_test;
    localparam int N = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 1'b0, prog_done_i = 1'b0, shutdown_i = 1'b0;
    logic slot_rst_n_o, core_rst_n_o, slot_pwr_en_o, aux_clk_en_o;
    logic phy_hold_rst_o, pwrup_rst_n_o, link_train_en_o, busy_o, phy_prog_go_o;
    logic [3:0] dev_type_o;

    int checks = 0, failures = 0;
    bit mon_en = 1'b0, finished = 1'b0;

    typedef struct {
        logic [12:0] vec;
        int          gap;
        string       tag;
    } item_t;
    item_t exp_q[$];

    always #4 clk = ~clk;

    pcie_host_bringup #(.HOLD_CYCLES(N)) uut (.*);

    function automatic logic [12:0] mk(bit sl, bit co, bit pw, bit ax, bit ho,
                                       bit pu, logic [3:0] dt, bit lk, bit bz, bit go);
        return {sl, co, pw, ax, ho, pu, dt, lk, bz, go};
    endfunction

    function automatic logic [12:0] snap();
        return {slot_rst_n_o, core_rst_n_o, slot_pwr_en_o, aux_clk_en_o, phy_hold_rst_o,
                pwrup_rst_n_o, dev_type_o, link_train_en_o, busy_o, phy_prog_go_o};
    endfunction

    task automatic push(logic [12:0] v, int gap, string tag);
        exp_q.push_back('{vec: v, gap: gap, tag: tag});
    endtask

    task automatic check_now(logic [12:0] v, string tag);
        checks++;
        if (snap() !== v) begin
            failures++;
            $display("FAIL %s: outputs %b expected %b", tag, snap(), v);
        end
    endtask

    task automatic pulse(ref logic sig);
        sig = 1'b1;
        @(negedge clk);
        sig = 1'b0;
    endtask

    task automatic push_front_half();
        push(mk(0,0,1,0,0,0,0,0,1,0), -1, "R2");
        push(mk(0,1,1,0,0,0,0,0,1,0),  N, "R3");
        push(mk(1,1,1,0,0,0,0,0,1,0),  1, "R3");
        push(mk(1,1,1,1,0,0,0,0,1,0),  1, "R4");
        push(mk(1,1,1,1,1,0,0,0,1,0),  1, "R4");
        push(mk(1,1,1,1,1,1,0,0,1,1),  1, "R5");
        push(mk(1,1,1,1,1,1,0,0,1,0),  1, "R5");
    endtask

    task automatic push_back_half(int k);
        push(mk(1,1,1,0,1,1,0,0,1,0),  k, "R5");
        push(mk(1,1,1,0,0,1,0,0,1,0),  1, "R6");
        push(mk(1,1,1,1,0,1,0,0,1,0),  1, "R6");
        push(mk(1,1,1,1,0,1,4,0,1,0),  1, "R7");
        push(mk(1,1,1,1,0,1,4,1,0,0),  1, "R7");
    endtask

    task automatic wait_go();
        while (phy_prog_go_o !== 1'b1) @(negedge clk);
    endtask

    // full bring-up; noise injects stray start/done during the hold wait
    task automatic bringup(int k, bit noise);
        push_front_half();
        push_back_half(k);
        pulse(start_i);
        if (noise) begin
            repeat (5) @(negedge clk);
            start_i = 1'b1; prog_done_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0; prog_done_i = 1'b0;
        end
        wait_go();
        repeat (k) @(negedge clk);
        pulse(prog_done_i);
        while (link_train_en_o !== 1'b1) @(negedge clk);
    endtask

    task automatic shutdown_from_link();
        push(mk(0,1,1,1,0,1,4,0,0,0), -1, "R9");
        push(mk(0,0,1,1,0,1,4,0,0,0),  1, "R9");
        push('0, 1, "R9");
        pulse(shutdown_i);
        repeat (4) @(negedge clk);
        check_now('0, "R9 idle after shutdown");
    endtask

    // monitor: every output change must match the next expected item
    initial begin
        logic [12:0] prev, cur;
        int cyc, last;
        item_t it;
        wait (mon_en);
        prev = snap(); cyc = 0; last = 0;
        forever begin
            @(negedge clk);
            cyc++;
            cur = snap();
            if (cur !== prev) begin
                checks++;
                if (exp_q.size() == 0) begin
                    failures++;
                    $display("FAIL R8/R9 unexpected change: outputs %b expected %b", cur, prev);
                end else begin
                    it = exp_q.pop_front();
                    if (cur !== it.vec || (it.gap >= 0 && cyc - last != it.gap)) begin
                        failures++;
                        $display("FAIL %s: outputs %b gap %0d expected %b gap %0d",
                                 it.tag, cur, cyc - last, it.vec, it.gap);
                    end
                end
                last = cyc;
                prev = cur;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; failures++;
            $display("FAIL watchdog: sequence hung, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check_now('0, "R1 during reset");
        rst = 1'b0;
        @(negedge clk);
        check_now('0, "R1 after reset");
        mon_en = 1'b1;
        repeat (3) @(negedge clk);

        // R1 idle holds without start; R9 shutdown in idle ignored
        pulse(shutdown_i);
        repeat (8) @(negedge clk);
        check_now('0, "R9 shutdown in idle");

        // main sequence with stray start (R8) and early done (R5) during wait
        bringup(3, 1'b1);
        pulse(start_i);
        repeat (10) @(negedge clk);
        check_now(mk(1,1,1,1,0,1,4,1,0,0), "R8 start at link up");
        shutdown_from_link();

        // restart, immediate done
        bringup(1, 1'b0);
        shutdown_from_link();

        // shutdown while waiting for programming
        push_front_half();
        pulse(start_i);
        wait_go();
        repeat (3) @(negedge clk);
        push(mk(0,1,1,1,1,1,0,0,0,0), -1, "R9");
        push(mk(0,0,1,1,1,1,0,0,0,0),  1, "R9");
        push('0, 1, "R9");
        pulse(shutdown_i);
        repeat (4) @(negedge clk);
        check_now('0, "R9 after programming abort");

        // shutdown during the power hold wait
        push(mk(0,0,1,0,0,0,0,0,1,0), -1, "R2");
        push(mk(0,0,1,0,0,0,0,0,0,0), -1, "R9");
        push('0, 2, "R9");
        pulse(start_i);
        repeat (3) @(negedge clk);
        pulse(shutdown_i);
        repeat (5) @(negedge clk);
        check_now('0, "R9 after hold abort");

        repeat (5) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            failures++;
            $display("FAIL R3/R7 missing changes: pending %0d expected 0", exp_q.size());
        end
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule